// File: doc/BRIEF.md
# Extended-Frame Serial Transmitter

This block serialises characters onto a single line in UART framing. A character is 5, 6, 7, 8, 9, 13, 14, 15 or 16 bits wide. Software first writes the upper part of a wide character to a byte-wide extension register. It then writes the low byte, and that write commits the whole character as one unit. Characters of 8 bits or fewer need only the low-byte write. A one-deep holding buffer sits ahead of the shifter, so the next character can be queued while the current one is on the line. Software polls `buf_empty` before each write.

Bit boundaries follow `bit_tick`. In asynchronous mode this is the `baud_tick` input, one pulse per bit period. In synchronous mode it is the rising edge of `ext_clk`, passed through a synchroniser. The frame is:

1. a low start bit;
2. the data bits, least significant first;
3. an optional parity bit;
4. one or two high stop bits.

The shift state machine has six states: IDLE, START, DATA, PARITY, STOP1 and STOP2. All transitions except the last below happen on `bit_tick`:

- IDLE→START when the buffer is full and the transmitter is enabled; this takes the character from the buffer.
- START→DATA.
- DATA→DATA while data bits remain.
- DATA→PARITY after the last data bit when parity is on.
- DATA→STOP1 after the last data bit when parity is off.
- PARITY→STOP1.
- STOP1→STOP2 when two stop bits are set.
- STOP1 or STOP2 → START when another character is waiting (back-to-back).
- STOP1 or STOP2 → IDLE otherwise.
- Any state → IDLE on reset.

Top module: `xframe_tx`

## Requirements
- R1: After reset `txd` is 1, `txd_oe` is 0, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame is one low start bit, then the data bits least significant first, then the stop bits (one, or two when `two_stop`=1), all high. Every bit lasts one `bit_tick` period. The line idles high.
- R3: `len_sel` chooses the data length: 0→5, 1→6, 2→7, 3→8, 4→9, 5→13, 6→14, 7→15, 8→16 bits.
- R4: `par_mode` 2'b10 appends an even-parity bit and 2'b11 an odd-parity bit, after the data bits. Values 2'b00 and 2'b01 send no parity bit.
- R5: `ext_wr` latches `ext_data` as bits 15:8 of the next character; the commit on `dat_wr` fixes them. `ext_wr` alone starts no frame and leaves `buf_empty` unchanged.
- R6: Character bits above the configured length are neither sent nor counted in parity.
- R7: A `dat_wr` while `buf_empty`=1 fills the buffer, and `buf_empty` reads 0 on the next cycle. A `dat_wr` while `buf_empty`=0 is ignored.
- R8: The buffer moves into the shifter at the tick that begins the start bit, and `buf_empty` rises in that same cycle. A character waiting at the end of the last stop bit follows it with no idle gap.
- R9: `tx_done` rises when the last stop bit ends with the buffer empty. An accepted `dat_wr` clears it.
- R10: While `tx_en`=0, `txd_oe` is 0, `txd` is 1 and no frame starts. A buffered character is kept and sent once `tx_en` returns to 1.
- R11: With `sync_mode`=1 each rising edge of `ext_clk` advances one bit and `baud_tick` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable and line ownership |
| sync_mode | input | 1 | 1: bits timed by `ext_clk` |
| baud_tick | input | 1 | One-cycle pulse per bit period (async mode) |
| ext_clk | input | 1 | External shift clock (sync mode) |
| len_sel | input | 4 | Data length code |
| par_mode | input | 2 | Parity select |
| two_stop | input | 1 | 1: two stop bits |
| ext_wr | input | 1 | Write strobe for the extension register |
| ext_data | input | 8 | Character bits 15:8 |
| dat_wr | input | 1 | Low-byte write strobe; commits the character |
| dat_data | input | 8 | Character bits 7:0 |
| buf_empty | output | 1 | Holding buffer can accept a character |
| tx_done | output | 1 | Transmission finished, nothing queued |
| txd | output | 1 | Serial data line |
| txd_oe | output | 1 | Block drives the line |

## Verification
A wrong state or bit counter appears at `txd` within one bit period: the frame shows too many or too few data bits, a missing or wrong parity bit, or a stop bit that comes early. A lost or duplicated buffer transfer appears at `buf_empty` in the cycle of the start tick. It also appears on the line as a dropped or repeated character in back-to-back traffic. A bad done flag is visible one tick after the final stop bit. Sampling each bit in the middle of its period checks frame length and bit order together.

// File: rtl/xtx_pkg.sv
package xtx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2
    } tx_state_e;

    function automatic logic [4:0] bits_of(input logic [3:0] code);
        unique case (code)
            4'd0: return 5'd5;
            4'd1: return 5'd6;
            4'd2: return 5'd7;
            4'd3: return 5'd8;
            4'd4: return 5'd9;
            4'd5: return 5'd13;
            4'd6: return 5'd14;
            4'd7: return 5'd15;
            4'd8: return 5'd16;
            default: return 5'd8;
        endcase
    endfunction
endpackage

// File: rtl/xtx_tick.sv
module xtx_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic baud_tick,
    input  logic ext_clk,
    output logic bit_tick
);
    logic [SYNC_STAGES:0] chain;
    logic                 ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], ext_clk};
    end

    assign ext_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    assign bit_tick = sync_mode ? ext_rise : baud_tick;
endmodule

// File: rtl/xtx_hold.sv
module xtx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_wr,
    input  logic [BYTE_W-1:0]   ext_data,
    input  logic                dat_wr,
    input  logic [BYTE_W-1:0]   dat_data,
    input  logic                take,
    output logic                full,
    output logic                accept,
    output logic [2*BYTE_W-1:0] word
);
    logic [BYTE_W-1:0] ext_q;

    assign accept = dat_wr && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
            full  <= 1'b0;
            word  <= '0;
        end else begin
            if (ext_wr) ext_q <= ext_data;
            if (accept) begin
                word <= {ext_q, dat_data};
                full <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xtx_fsm.sv
module xtx_fsm
    import xtx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_word,
    input  logic              clr_done,
    input  logic [3:0]        len_sel,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    output logic              take,
    output logic              line_bit,
    output logic              done
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    tx_state_e         state, state_nx;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              par_bit;
    logic [4:0]        nbits;
    logic [WORD_W-1:0] mask;
    logic              start_ok;
    logic              finish;

    assign nbits    = bits_of(len_sel);
    assign mask     = WORD_W'((32'd1 << nbits) - 32'd1);
    assign start_ok = tx_en && hold_full && bit_tick;

    always_comb begin
        state_nx = state;
        take     = 1'b0;
        finish   = 1'b0;
        unique case (state)
            ST_IDLE: if (start_ok) begin
                state_nx = ST_START;
                take     = 1'b1;
            end
            ST_START: if (bit_tick) state_nx = ST_DATA;
            ST_DATA: if (bit_tick && (5'(cnt) == nbits - 5'd1))
                state_nx = par_mode[1] ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_tick) state_nx = ST_STOP1;
            ST_STOP1, ST_STOP2: if (bit_tick) begin
                if (state == ST_STOP1 && two_stop) begin
                    state_nx = ST_STOP2;
                end else if (start_ok) begin
                    state_nx = ST_START;
                    take     = 1'b1;
                end else begin
                    state_nx = ST_IDLE;
                    finish   = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            cnt     <= '0;
            par_bit <= 1'b0;
            done    <= 1'b0;
        end else begin
            if (take) begin
                shreg   <= hold_word & mask;
                cnt     <= '0;
                par_bit <= (^(hold_word & mask)) ^ par_mode[0];
            end else if (state == ST_DATA && bit_tick) begin
                shreg <= shreg >> 1;
                cnt   <= cnt + 1'b1;
            end
            if (clr_done)    done <= 1'b0;
            else if (finish) done <= !hold_full;
        end
    end

    always_comb begin
        unique case (state)
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = shreg[0];
            ST_PARITY: line_bit = par_bit;
            default:   line_bit = 1'b1;
        endcase
    end
endmodule

// File: rtl/xframe_tx.sv
module xframe_tx #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              sync_mode,
    input  logic              baud_tick,
    input  logic              ext_clk,
    input  logic [3:0]        len_sel,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic              ext_wr,
    input  logic [BYTE_W-1:0] ext_data,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] dat_data,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              txd,
    output logic              txd_oe
);
    localparam int WORD_W = 2 * BYTE_W;

    logic              bit_tick, take, full, accept, line_bit;
    logic [WORD_W-1:0] word;

    xtx_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
        .baud_tick(baud_tick), .ext_clk(ext_clk), .bit_tick(bit_tick)
    );

    xtx_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .ext_wr(ext_wr), .ext_data(ext_data),
        .dat_wr(dat_wr), .dat_data(dat_data), .take(take),
        .full(full), .accept(accept), .word(word)
    );

    xtx_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .hold_full(full), .hold_word(word), .clr_done(accept),
        .len_sel(len_sel), .par_mode(par_mode), .two_stop(two_stop),
        .take(take), .line_bit(line_bit), .done(tx_done)
    );

    assign buf_empty = !full;
    assign txd       = tx_en ? line_bit : 1'b1;
    assign txd_oe    = tx_en;
endmodule

// File: rtl/xtx_chk.sv
module xtx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              sync_mode,
    input logic              baud_tick,
    input logic              dat_wr,
    input logic              buf_empty,
    input logic              tx_done,
    input logic              txd,
    input logic              txd_oe
);
    // R7
    commit_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr && buf_empty |=> !buf_empty);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr && buf_empty |=> !tx_done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> buf_empty && txd);

    // R8
    transfer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> !txd);

    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> txd && !txd_oe);

    // R2
    tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode && !baud_tick && tx_en |=> $stable(txd) || !tx_en);
endmodule

bind xframe_tx xtx_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tb_xframe_tx.sv
module tb_xframe_tx;
    localparam int PER  = 8;
    localparam int SPER = 16;
    localparam int NV   = 7;
    // {len_sel[3:0], par_mode[1:0], two_stop, ext[7:0], low[7:0]}
    localparam logic [22:0] VEC [NV] = '{
        {4'd3, 2'b00, 1'b0, 8'h00, 8'hA5},
        {4'd0, 2'b10, 1'b0, 8'hFF, 8'hFF},
        {4'd4, 2'b11, 1'b1, 8'h01, 8'h3C},
        {4'd5, 2'b10, 1'b0, 8'hFF, 8'h81},
        {4'd8, 2'b11, 1'b1, 8'hC3, 8'h5A},
        {4'd7, 2'b01, 1'b0, 8'hAA, 8'h0F},
        {4'd1, 2'b11, 1'b0, 8'h00, 8'h2A}
    };

    logic clk = 0, rst_n = 0, tx_en = 0, sync_mode = 0, baud_tick = 0, ext_clk = 0;
    logic [3:0] len_sel = 4'd3;
    logic [1:0] par_mode = 2'b00;
    logic two_stop = 0, ext_wr = 0, dat_wr = 0;
    logic [7:0] ext_data = 0, dat_data = 0;
    logic buf_empty, tx_done, txd, txd_oe;
    logic tick_on = 0, eclk_on = 0;
    int checks = 0, errors = 0;

    xframe_tx dut (.*);

    always #5 clk = ~clk;

    initial begin : tick_gen
        int c = 0;
        forever begin
            @(negedge clk);
            if (tick_on) begin
                c = (c == PER - 1) ? 0 : c + 1;
                baud_tick = (c == 0);
            end else begin
                baud_tick = 0;
            end
        end
    end

    initial begin : eclk_gen
        int c = 0;
        forever begin
            @(negedge clk);
            if (eclk_on) begin
                c = c + 1;
                if (c == SPER / 2) begin
                    c = 0;
                    ext_clk = ~ext_clk;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int nbits(input logic [3:0] c);
        case (c)
            4'd0: return 5;  4'd1: return 6;  4'd2: return 7;
            4'd3: return 8;  4'd4: return 9;  4'd5: return 13;
            4'd6: return 14; 4'd7: return 15; default: return 16;
        endcase
    endfunction

    task automatic setup(input logic [3:0] l, input logic [1:0] p, input logic s);
        @(negedge clk);
        len_sel = l; par_mode = p; two_stop = s;
    endtask

    task automatic put_ext(input logic [7:0] d);
        @(negedge clk); ext_wr = 1; ext_data = d;
        @(negedge clk); ext_wr = 0;
    endtask

    task automatic put_dat(input logic [7:0] d);
        @(negedge clk); dat_wr = 1; dat_data = d;
        @(negedge clk); dat_wr = 0;
    endtask

    // Samples one frame, middle-aligned; returns at the first cycle of the next bit.
    task automatic grab(input logic [3:0] l, input logic [1:0] p, input logic s,
                        input logic [15:0] w, input int per, input string tag);
        logic [31:0] exp = '1, got = '1;
        int n = 0, guard = 0, len = nbits(l);
        logic par = 0;
        exp[n] = 1'b0; n++;
        for (int i = 0; i < len; i++) begin
            exp[n] = w[i]; par ^= w[i]; n++;
        end
        if (p[1]) begin exp[n] = par ^ p[0]; n++; end
        exp[n] = 1'b1; n++;
        if (s) begin exp[n] = 1'b1; n++; end
        while (txd !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        for (int i = 0; i < n; i++) begin
            repeat (per / 2) @(negedge clk);
            got[i] = txd;
            repeat (per - per / 2) @(negedge clk);
        end
        chk(got == exp, tag, got, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1 txd", 32'(txd), 1);
        chk(txd_oe === 1'b0, "R1 txd_oe", 32'(txd_oe), 0);
        chk(buf_empty === 1'b1, "R1 buf_empty", 32'(buf_empty), 1);
        chk(tx_done === 1'b0, "R1 tx_done", 32'(tx_done), 0);
        rst_n = 1; tx_en = 1; tick_on = 1;
        repeat (4) @(negedge clk);

        // R2 R3 R4 R6 table walk
        for (int v = 0; v < NV; v++) begin
            setup(VEC[v][22:19], VEC[v][18:17], VEC[v][16]);
            put_ext(VEC[v][15:8]);
            put_dat(VEC[v][7:0]);
            grab(VEC[v][22:19], VEC[v][18:17], VEC[v][16], VEC[v][15:0], PER, "R2/R3/R4/R6 frame");
            chk(tx_done === 1'b1 && txd === 1'b1, "R9 done after frame", 32'(tx_done), 1);
        end

        // R9 done cleared by accepted write; R5 ext-only write starts nothing
        setup(4'd3, 2'b00, 1'b0);
        put_dat(8'h11);
        chk(tx_done === 1'b0, "R9 done cleared", 32'(tx_done), 0);
        grab(4'd3, 2'b00, 1'b0, 16'h0011, PER, "R2 frame 0x11");
        put_ext(8'h7E);
        begin
            bit quiet = 1;
            repeat (4 * PER) begin @(negedge clk); if (txd !== 1'b1) quiet = 0; end
            chk(quiet && buf_empty === 1'b1, "R5 ext write alone", 32'(buf_empty), 1);
        end

        // R7 R8 back-to-back, third write ignored
        setup(4'd3, 2'b10, 1'b0);
        put_dat(8'hC6);
        while (!buf_empty) @(negedge clk);
        fork
            grab(4'd3, 2'b10, 1'b0, 16'h00C6, PER, "R8 first of pair");
            begin
                put_dat(8'h39);
                chk(buf_empty === 1'b0, "R7 buffer filled", 32'(buf_empty), 0);
                put_dat(8'h00);
            end
        join
        grab(4'd3, 2'b10, 1'b0, 16'h0039, PER, "R8 second of pair, no gap");
        begin
            bit quiet = 1;
            repeat (4 * PER) begin @(negedge clk); if (txd !== 1'b1) quiet = 0; end
            chk(quiet && tx_done === 1'b1, "R7 write while full ignored", 32'(quiet), 1);
        end

        // R10 disabled transmitter keeps character
        @(negedge clk); tx_en = 0;
        put_dat(8'h96);
        repeat (6 * PER) @(negedge clk);
        chk(txd === 1'b1 && txd_oe === 1'b0, "R10 line released", {txd, txd_oe}, 2'b10);
        chk(buf_empty === 1'b0, "R10 character kept", 32'(buf_empty), 0);
        @(negedge clk); tx_en = 1;
        grab(4'd3, 2'b10, 1'b0, 16'h0096, PER, "R10 sent after enable");

        // R11 synchronous mode
        setup(4'd6, 2'b11, 1'b1);
        @(negedge clk); sync_mode = 1;
        put_ext(8'h2D);
        put_dat(8'hB4);
        repeat (6 * PER) @(negedge clk);
        chk(txd === 1'b1 && buf_empty === 1'b0, "R11 baud_tick ignored", 32'(txd), 1);
        eclk_on = 1;
        grab(4'd6, 2'b11, 1'b1, 16'h2DB4, SPER, "R11 frame on ext_clk");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule